// File: doc/BRIEF.md
# Packet Buffer Page Allocator

The block keeps track of a shared packet memory that is carved into fixed 256-byte pages. The host drives a command port; while a command runs the block holds `busy` high for a fixed number of cycles, and the command's effect becomes visible on the cycle `busy` drops. A transmit allocation asks for a number of pages and receives a packet number, or a failure flag when no free run of that length exists. An enqueue hands the last allocated packet to the transmitter. Two release commands return the pages of the packet at the head of either packet-number FIFO. A reset command clears everything.

The receive side asks for pages on its own request line whenever the command engine is idle. A granted request puts the new packet number into the receive FIFO. The transmitter reports each finished packet number, and those numbers are queued in a completion FIFO. Pages are handed out as one contiguous run at the lowest start page that fits. Packet numbers are handed out lowest first.

Top module: `pkt_page_alloc`

## Requirements
- R1: A command with `cmd_op`=1 allocates `cmd_pages` pages, where a count of 0 counts as 1. It takes the lowest-starting run of contiguous free pages and the lowest unused packet number. `res_pkt` shows that number and `res_fail` reads 0.
- R2: If no contiguous free run of the needed length exists (including a count above NUM_PAGES), `res_fail` reads 1 and `res_pkt` reads 0. No page is taken and `alloc_irq` is not set.
- R3: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. `busy` is then high for exactly CMD_CYCLES cycles, and results appear when it falls. A command presented while `busy` is high is ignored.
- R4: `alloc_irq` is set by a successful `cmd_op`=1 allocation and stays set until a cycle with `irq_ack` high clears it.
- R5: `cmd_op`=2 gives a one-cycle `tx_go` pulse carrying `res_pkt` in `tx_go_pkt`, in the cycle `busy` falls. When `res_fail` is 1 there is no pulse.
- R6: A cycle with `tx_done` high pushes `tx_done_pkt` into the completion FIFO. `txc_pkt` shows the oldest entry and `txc_empty` is 1 when the FIFO holds none.
- R7: `cmd_op`=4 frees the pages and packet number of the completion-FIFO head and pops it. On an empty FIFO it changes nothing.
- R8: With `busy` and `cmd_valid` low, `rx_req` allocates `rx_pages` pages using the rules of R1. On success the packet number is pushed into the receive FIFO. `rx_ack` pulses on the next cycle, and `rx_fail` is 1 with the FIFO unchanged when no run fits.
- R9: `cmd_op`=3 frees the pages and packet number of the receive-FIFO head and pops it. `rxf_pkt` and `rxf_empty` show the head and the empty state. On an empty FIFO the command changes nothing.
- R10: `cmd_op`=5 and the hardware reset both free all pages and numbers and empty both FIFOs. They also set `res_fail`=1 and `res_pkt`=0 and clear `alloc_irq`.
- R11: The op codes 0, 6 and 7 are accepted and raise `busy`, but they have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_pages | input | CNT_W (6) | Page count for an allocation |
| busy | output | 1 | Command in progress |
| res_pkt | output | PKT_W (5) | Allocation result packet number |
| res_fail | output | 1 | Allocation failed / no valid result |
| alloc_irq | output | 1 | Allocation-complete status |
| irq_ack | input | 1 | Clears alloc_irq |
| tx_go | output | 1 | Packet handed to the transmitter |
| tx_go_pkt | output | PKT_W (5) | Packet number handed over |
| tx_done | input | 1 | Transmitter finished a packet |
| tx_done_pkt | input | PKT_W (5) | Number of the finished packet |
| txc_pkt | output | PKT_W (5) | Completion-FIFO head |
| txc_empty | output | 1 | Completion FIFO empty |
| rx_req | input | 1 | Receive-side page request |
| rx_pages | input | CNT_W (6) | Pages wanted by the receive side |
| rx_ack | output | 1 | Receive request handled |
| rx_fail | output | 1 | Receive request found no room |
| rxf_pkt | output | PKT_W (5) | Receive-FIFO head |
| rxf_empty | output | 1 | Receive FIFO empty |

## Verification
A corrupt page bitmap shows up at the next allocation that touches the affected pages. It returns a wrong packet number, fails when it should succeed, or succeeds into fragmented space where the model predicts a failure. Fragmentation scenarios are built on purpose so that the first-fit start page can be seen through the success or failure of later requests. A wrong FIFO pointer or count shows up at once in the head number or the empty flag, checked after every operation. A wrong busy counter is caught on the command that runs too long or too short.

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc #(
  parameter int NUM_PAGES  = 32,
  parameter int PKT_W      = 5,
  parameter int CMD_CYCLES = 3,
  parameter int CNT_W      = $clog2(NUM_PAGES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [CNT_W-1:0] cmd_pages,
  output logic             busy,
  output logic [PKT_W-1:0] res_pkt,
  output logic             res_fail,
  output logic             alloc_irq,
  input  logic             irq_ack,
  output logic             tx_go,
  output logic [PKT_W-1:0] tx_go_pkt,
  input  logic             tx_done,
  input  logic [PKT_W-1:0] tx_done_pkt,
  output logic [PKT_W-1:0] txc_pkt,
  output logic             txc_empty,
  input  logic             rx_req,
  input  logic [CNT_W-1:0] rx_pages,
  output logic             rx_ack,
  output logic             rx_fail,
  output logic [PKT_W-1:0] rxf_pkt,
  output logic             rxf_empty
);
  localparam int NUM_PKTS = 1 << PKT_W;
  localparam int PG_W     = $clog2(NUM_PAGES);
  localparam int BC_W     = $clog2(CMD_CYCLES + 1);
  localparam int W2       = 2 * NUM_PAGES;
  localparam logic [2:0] OP_ALLOC = 3'd1;
  localparam logic [2:0] OP_ENQ   = 3'd2;
  localparam logic [2:0] OP_RXREL = 3'd3;
  localparam logic [2:0] OP_TXREL = 3'd4;
  localparam logic [2:0] OP_RESET = 3'd5;

  function automatic logic [NUM_PAGES-1:0] run_mask(input logic [PG_W-1:0] st,
                                                    input logic [CNT_W-1:0] n);
    logic [W2-1:0] t;
    t = ({{(W2-1){1'b0}}, 1'b1} << n) - {{(W2-1){1'b0}}, 1'b1};
    t = t << st;
    return t[NUM_PAGES-1:0];
  endfunction

  logic [NUM_PAGES-1:0] page_used;
  logic [NUM_PKTS-1:0]  pkt_used;
  logic [PG_W-1:0]      pkt_start [NUM_PKTS];
  logic [CNT_W-1:0]     pkt_len   [NUM_PKTS];
  logic [PKT_W-1:0]     txq [NUM_PKTS];
  logic [PKT_W-1:0]     rxq [NUM_PKTS];
  logic [PKT_W-1:0]     tx_rd, tx_wr, rx_rd, rx_wr;
  logic [PKT_W:0]       tx_cnt, rx_cnt;
  logic [BC_W-1:0]      bcnt;
  logic [2:0]           op_q;
  logic [CNT_W-1:0]     pg_q;

  wire accept = cmd_valid && !busy;
  wire exec   = busy && (bcnt == '0);
  wire rx_go  = !busy && !cmd_valid && rx_req;

  logic [CNT_W-1:0] req_n, need;
  logic             fit_ok, pkt_ok, alloc_ok;
  logic [PG_W-1:0]  fit_st;
  logic [PKT_W-1:0] new_pkt;

  always_comb begin
    req_n  = busy ? pg_q : rx_pages;
    need   = (req_n == '0) ? CNT_W'(1) : req_n;
    fit_ok = 1'b0;
    fit_st = '0;
    for (int s = NUM_PAGES - 1; s >= 0; s--) begin
      if ((int'(need) <= NUM_PAGES - s) &&
          ((run_mask(PG_W'(s), need) & page_used) == '0)) begin
        fit_ok = 1'b1;
        fit_st = PG_W'(s);
      end
    end
    pkt_ok  = 1'b0;
    new_pkt = '0;
    for (int p = NUM_PKTS - 1; p >= 0; p--) begin
      if (!pkt_used[p]) begin
        pkt_ok  = 1'b1;
        new_pkt = PKT_W'(p);
      end
    end
    alloc_ok = fit_ok && pkt_ok;
  end

  assign txc_empty = (tx_cnt == '0);
  assign rxf_empty = (rx_cnt == '0);
  assign txc_pkt   = txq[tx_rd];
  assign rxf_pkt   = rxq[rx_rd];

  wire cmd_alloc = exec && (op_q == OP_ALLOC);
  wire flush     = exec && (op_q == OP_RESET);
  wire tx_pop    = exec && (op_q == OP_TXREL) && !txc_empty;
  wire rx_pop    = exec && (op_q == OP_RXREL) && !rxf_empty;
  wire tx_push   = tx_done && (int'(tx_cnt) != NUM_PKTS);
  wire rx_push   = rx_go && alloc_ok;
  wire do_alloc  = (cmd_alloc || rx_go) && alloc_ok;
  wire do_rel    = tx_pop || rx_pop;
  wire [PKT_W-1:0]     rel_pkt  = tx_pop ? txq[tx_rd] : rxq[rx_rd];
  wire [NUM_PAGES-1:0] rel_mask = run_mask(pkt_start[rel_pkt], pkt_len[rel_pkt]);
  wire [NUM_PAGES-1:0] new_mask = run_mask(fit_st, need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_used <= '0;
      pkt_used  <= '0;
    end else if (flush) begin
      page_used <= '0;
      pkt_used  <= '0;
    end else if (do_rel) begin
      page_used         <= page_used & ~rel_mask;
      pkt_used[rel_pkt] <= 1'b0;
    end else if (do_alloc) begin
      page_used         <= page_used | new_mask;
      pkt_used[new_pkt] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      pkt_start[new_pkt] <= fit_st;
      pkt_len[new_pkt]   <= need;
    end
    if (tx_push) txq[tx_wr] <= tx_done_pkt;
    if (rx_push) rxq[rx_wr] <= new_pkt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rd <= '0; tx_wr <= '0; tx_cnt <= '0;
      rx_rd <= '0; rx_wr <= '0; rx_cnt <= '0;
    end else if (flush) begin
      tx_rd <= '0; tx_wr <= '0; tx_cnt <= '0;
      rx_rd <= '0; rx_wr <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wr <= tx_wr + 1'b1;
      if (tx_pop)  tx_rd <= tx_rd + 1'b1;
      if (tx_push && !tx_pop)      tx_cnt <= tx_cnt + 1'b1;
      else if (tx_pop && !tx_push) tx_cnt <= tx_cnt - 1'b1;
      if (rx_push) begin
        rx_wr  <= rx_wr + 1'b1;
        rx_cnt <= rx_cnt + 1'b1;
      end else if (rx_pop) begin
        rx_rd  <= rx_rd + 1'b1;
        rx_cnt <= rx_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bcnt      <= '0;
      op_q      <= '0;
      pg_q      <= '0;
      res_pkt   <= '0;
      res_fail  <= 1'b1;
      alloc_irq <= 1'b0;
      tx_go     <= 1'b0;
      tx_go_pkt <= '0;
      rx_ack    <= 1'b0;
      rx_fail   <= 1'b0;
    end else begin
      tx_go     <= exec && (op_q == OP_ENQ) && !res_fail;
      tx_go_pkt <= res_pkt;
      rx_ack    <= rx_go;
      rx_fail   <= rx_go && !alloc_ok;
      if (accept) begin
        busy <= 1'b1;
        bcnt <= BC_W'(CMD_CYCLES - 1);
        op_q <= cmd_op;
        pg_q <= cmd_pages;
      end else if (busy) begin
        if (bcnt == '0) busy <= 1'b0;
        else            bcnt <= bcnt - 1'b1;
      end
      if (flush) begin
        res_pkt   <= '0;
        res_fail  <= 1'b1;
        alloc_irq <= 1'b0;
      end else begin
        if (cmd_alloc) begin
          res_pkt  <= alloc_ok ? new_pkt : '0;
          res_fail <= !alloc_ok;
        end
        if (cmd_alloc && alloc_ok) alloc_irq <= 1'b1;
        else if (irq_ack)          alloc_irq <= 1'b0;
      end
    end
  end

  a_r1_pages_cover_pkts: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(page_used) >= $countones(pkt_used));
  a_r2_fail_keeps_pages: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_alloc && !alloc_ok |=> $stable(page_used) && res_fail);
  a_r3_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (bcnt != '0) |=> busy && $stable(op_q) && $stable(pg_q));
  a_r4_irq_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alloc_irq) |-> !res_fail);
  a_r5_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> !tx_go);
  a_r6_txc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_cnt) <= NUM_PKTS);
  a_r8_rxfail_fifo: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack && rx_fail |-> rx_cnt == $past(rx_cnt));
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> txc_empty && rxf_empty && (page_used == '0) && (pkt_used == '0));
endmodule

// File: tb/tb_pkt_page_alloc.sv
module tb_pkt_page_alloc;
  localparam int NP = 32, PW = 5, CC = 3, CW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, irq_ack = 1'b0, tx_done = 1'b0, rx_req = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [CW-1:0] cmd_pages = '0, rx_pages = '0;
  logic [PW-1:0] tx_done_pkt = '0;
  logic busy, res_fail, alloc_irq, tx_go, txc_empty, rx_ack, rx_fail, rxf_empty;
  logic [PW-1:0] res_pkt, tx_go_pkt, txc_pkt, rxf_pkt;

  pkt_page_alloc #(.NUM_PAGES(NP), .PKT_W(PW), .CMD_CYCLES(CC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pages(cmd_pages), .busy(busy), .res_pkt(res_pkt), .res_fail(res_fail),
    .alloc_irq(alloc_irq), .irq_ack(irq_ack), .tx_go(tx_go), .tx_go_pkt(tx_go_pkt),
    .tx_done(tx_done), .tx_done_pkt(tx_done_pkt), .txc_pkt(txc_pkt),
    .txc_empty(txc_empty), .rx_req(rx_req), .rx_pages(rx_pages), .rx_ack(rx_ack),
    .rx_fail(rx_fail), .rxf_pkt(rxf_pkt), .rxf_empty(rxf_empty));

  always #5 clk = ~clk;

  int vecs = 0, errs = 0;
  bit finished = 0;
  logic [NP-1:0] m_page = '0;
  logic [NP-1:0] m_pktu = '0;
  int m_st [NP];
  int m_ln [NP];
  int tq[$];
  int rq[$];
  int m_res = 0;
  bit m_fail = 1, m_irq = 0, m_enq = 0;

  task automatic chk(string tag, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int m_take(int n);
    int need, s, p;
    need = (n == 0) ? 1 : n;
    s = -1;
    for (int i = 0; i < NP && s < 0; i++) begin
      bit ok;
      ok = (i + need <= NP);
      for (int j = 0; j < need && ok; j++) if (m_page[i+j]) ok = 0;
      if (ok) s = i;
    end
    p = -1;
    for (int i = 0; i < NP && p < 0; i++) if (!m_pktu[i]) p = i;
    if (s < 0 || p < 0) return -1;
    for (int j = 0; j < need; j++) m_page[s+j] = 1'b1;
    m_pktu[p] = 1'b1; m_st[p] = s; m_ln[p] = need;
    return p;
  endfunction

  function automatic void m_free(int p);
    for (int j = 0; j < m_ln[p]; j++) m_page[m_st[p]+j] = 1'b0;
    m_pktu[p] = 1'b0;
  endfunction

  task automatic check_all(string tag);
    chk(tag, "txc_empty", int'(txc_empty), int'(tq.size() == 0));
    if (tq.size() != 0) chk(tag, "txc_pkt", int'(txc_pkt), tq[0]);
    chk(tag, "rxf_empty", int'(rxf_empty), int'(rq.size() == 0));
    if (rq.size() != 0) chk(tag, "rxf_pkt", int'(rxf_pkt), rq[0]);
    chk(tag, "res_fail", int'(res_fail), int'(m_fail));
    chk(tag, "res_pkt", int'(res_pkt), m_res);
    chk(tag, "alloc_irq", int'(alloc_irq), int'(m_irq));
  endtask

  task automatic wait_idle(string tag, input bit chk_len);
    int n;
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    if (chk_len) chk(tag, "busy_cycles", n, CC);
  endtask

  task automatic apply_model(int op, int pages);
    int p;
    case (op)
      1: begin
        p = m_take(pages);
        m_fail = (p < 0);
        m_res = (p < 0) ? 0 : p;
        if (p >= 0) begin m_irq = 1; m_enq = 0; end
      end
      2: if (!m_fail) m_enq = 1;
      3: if (rq.size() != 0) m_free(rq.pop_front());
      4: if (tq.size() != 0) m_free(tq.pop_front());
      5: begin
        m_page = '0; m_pktu = '0; tq.delete(); rq.delete();
        m_res = 0; m_fail = 1; m_irq = 0; m_enq = 0;
      end
      default: ;
    endcase
  endtask

  task automatic do_cmd(string tag, int op, int pages);
    bit exp_go;
    int exp_pkt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_pages = CW'(pages);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(tag, "busy_rise", int'(busy), 1);
    wait_idle(tag, 1);
    exp_go = (op == 2) && !m_fail;
    exp_pkt = m_res;
    chk(tag, "tx_go", int'(tx_go), int'(exp_go));
    if (exp_go) chk(tag, "tx_go_pkt", int'(tx_go_pkt), exp_pkt);
    apply_model(op, pages);
    check_all(tag);
  endtask

  task automatic do_rx(string tag, int pages);
    int p;
    @(negedge clk);
    rx_req = 1'b1; rx_pages = CW'(pages);
    @(negedge clk);
    rx_req = 1'b0;
    p = m_take(pages);
    if (p >= 0) rq.push_back(p);
    chk(tag, "rx_ack", int'(rx_ack), 1);
    chk(tag, "rx_fail", int'(rx_fail), int'(p < 0));
    check_all(tag);
  endtask

  task automatic do_txdone(string tag, int p);
    @(negedge clk);
    tx_done = 1'b1; tx_done_pkt = PW'(p);
    @(negedge clk);
    tx_done = 1'b0;
    tq.push_back(p);
    check_all(tag);
  endtask

  task automatic do_ack(string tag);
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    m_irq = 0;
    check_all(tag);
  endtask

  task automatic enq_and_send(string tag);
    int p;
    p = m_res;
    do_cmd(tag, 2, 0);
    do_txdone(tag, p);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd715));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "busy_reset", int'(busy), 0);
    check_all("R10");

    do_cmd("R1", 1, 0);
    do_cmd("R4", 1, 3);
    do_ack("R4");
    do_cmd("R10", 5, 0);

    do_cmd("R1", 1, 8);
    do_cmd("R1", 1, 8);
    enq_and_send("R5");
    do_cmd("R1", 1, 8);
    do_cmd("R1", 1, 8);
    do_cmd("R2", 1, 1);
    do_cmd("R5", 2, 0);
    do_cmd("R7", 4, 0);
    do_cmd("R2", 1, 9);
    do_cmd("R1", 1, 8);
    do_cmd("R7", 4, 0);
    do_cmd("R9", 3, 0);
    do_cmd("R11", 6, 0);
    do_cmd("R11", 0, 0);
    do_cmd("R10", 5, 0);
    do_cmd("R2", 1, 33);
    do_rx("R8", 4);
    do_rx("R8", 30);
    do_rx("R8", 0);
    do_cmd("R9", 3, 0);
    do_cmd("R1", 1, 5);
    do_cmd("R9", 3, 0);

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_pages = CW'(2);
    @(negedge clk);
    cmd_op = 3'd1; cmd_pages = CW'(1);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle("R3", 0);
    apply_model(1, 2);
    @(negedge clk);
    chk("R3", "busy_after_ignored", int'(busy), 0);
    check_all("R3");
    do_cmd("R3", 1, 1);

    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0, 1, 2: do_cmd("R1", 1, ($urandom_range(0, 15) == 0) ? 40 : $urandom_range(0, 10));
        3: if (!m_fail && !m_enq) enq_and_send("R6"); else do_cmd("R5", 2, 0);
        4, 5: do_rx("R8", $urandom_range(0, 6));
        6: do_cmd("R9", 3, 0);
        7: do_cmd("R7", 4, 0);
        8: do_ack("R4");
        default: if ($urandom_range(0, 9) == 0) do_cmd("R10", 5, 0);
                 else do_cmd("R11", 7, $urandom_range(0, 5));
      endcase
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule